// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits on the host side of a PCI bridge and turns a two-register programming model into configuration transactions. Software first loads a selector register with the target bus, device, function, dword register index and cycle type. Loading it causes no bus activity. A later read or write of the data window launches one configuration request toward a PCI cycle engine.

That request carries the address-phase word, the command code, the byte enables and the write data. The block builds the Type 0 form, which has a one-hot IDSEL line for devices 0 to 15 and none for devices 16 to 31. It also builds the Type 1 form, which forwards the full target triple. The host waits on a ready handshake until the engine completes the request, times out, or reports a master abort.

Data-window accesses are accepted only while the bridge master-enable bit is set. While it is clear, the block gives no answer to the host at all. A sticky status bit records master aborts until software clears it.

Top module: `cfg_xlate`

## Requirements
- R1: A write to the selector (host_sel = 2'b00) stores bits [23:0] and raises no eng_req. Reading the selector returns the stored bits with [31:24] always zero. Field layout: bus [23:16], device [15:11], function [10:8], register index [7:2], bit 0 = cycle type (0 Type 0, 1 Type 1).
- R2: Each accepted data-window access (host_sel = 2'b01) raises eng_req exactly once and holds eng_addr, eng_cmd, eng_be and eng_wdata stable while eng_req is high. The command is 4'b1010 for a read and 4'b1011 for a write. host_be is passed to eng_be unchanged, and on a write host_wdata is passed to eng_wdata.
- R3: For Type 0 with device 0 to 15, eng_addr has exactly one bit set in [31:16], namely bit 16+device. It carries the function in [10:8], the register index in [7:2], 2'b00 in [1:0], and zero in [15:11].
- R4: For Type 0 with device 16 to 31, eng_addr[31:16] is all zero. The lower fields are encoded as in R3.
- R5: For Type 1, eng_addr = {8'h00, bus, device, function, register, 2'b01}.
- R6: While master_en is low, a data-window access raises neither eng_req nor host_ready.
- R7: The host sees host_ready for exactly one cycle. For a data access, this happens on the cycle after eng_done is sampled. A normal read returns eng_rdata with host_err low.
- R8: If eng_done has not arrived after tmo_cycles cycles of eng_req (a value of 0 acts as 1), eng_req drops. The access then ends with host_err high and host_rdata = 32'hFFFFFFFF.
- R9: An eng_done with eng_mabort ends the access with host_err low. A read returns 32'hFFFFFFFF and a write is discarded. Bit 0 of the status register (host_sel = 2'b10) is set and stays set until a write with bit 0 = 1 clears it. Writing 0 leaves it unchanged.
- R10: An access to host_sel = 2'b11 completes in one cycle with read data zero and no engine request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Bridge master-enable bit; gates data-window access |
| tmo_cycles | input | TMO_W | Completion timeout in clock cycles |
| host_valid | input | 1 | Host access request, held until host_ready |
| host_sel | input | 2 | 00 selector, 01 data window, 10 status, 11 unmapped |
| host_wr | input | 1 | 1 write, 0 read |
| host_wdata | input | DATA_W | Host write data |
| host_be | input | DATA_W/8 | Host byte enables |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read data, valid with host_ready |
| host_err | output | 1 | Timeout flag, valid with host_ready |
| eng_req | output | 1 | Configuration request to the cycle engine |
| eng_addr | output | 32 | Address-phase word |
| eng_cmd | output | 4 | Bus command code |
| eng_be | output | DATA_W/8 | Byte enables to the engine |
| eng_wdata | output | DATA_W | Write data to the engine |
| eng_done | input | 1 | Engine completion |
| eng_rdata | input | DATA_W | Engine read data, valid with eng_done |
| eng_mabort | input | 1 | Master abort, valid with eng_done |

## Verification
The bench builds the block with DATA_W = 32 and TMO_W = 4, which keeps the timeout window a few cycles long. It sweeps every device number 0 to 31 in Type 0 form, with function and register index varying alongside, so that each IDSEL line and the all-zero region are covered. It then sweeps the Type 1 form across bus numbers. With the short counter, both the exact timeout length and the zero-limit case can be reached and counted cycle by cycle. These runs are mixed with master aborts, a gated master enable and clearing of the sticky status bit.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam logic [1:0] SEL_ADDR = 2'b00;
  localparam logic [1:0] SEL_DATA = 2'b01;
  localparam logic [1:0] SEL_STAT = 2'b10;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  localparam int SELR_W = 24;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_t;
endpackage

// File: rtl/cfg_sel_regs.sv
module cfg_sel_regs
  import cfg_xlate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel_en,
  input  logic              wr_stat_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_mabort,
  output logic [SELR_W-1:0] sel_q,
  output logic              mabort_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      mabort_q <= 1'b0;
    end else begin
      if (wr_sel_en) sel_q <= wdata[SELR_W-1:0];
      if (set_mabort)
        mabort_q <= 1'b1;
      else if (wr_stat_en && wdata[0])
        mabort_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_phase_enc.sv
module cfg_phase_enc
  import cfg_xlate_pkg::*;
#(
  parameter int IDSEL_BASE = 16,
  parameter int IDSEL_N    = 16
) (
  input  logic [SELR_W-1:0] sel_q,
  output logic [31:0]       phase
);
  localparam int DEV_W = 5;

  logic [7:0]         bus;
  logic [DEV_W-1:0]   dev;
  logic [2:0]         fn;
  logic [5:0]         regi;
  logic               type1;
  logic [IDSEL_N-1:0] idsel;

  assign bus   = sel_q[23:16];
  assign dev   = sel_q[15:11];
  assign fn    = sel_q[10:8];
  assign regi  = sel_q[7:2];
  assign type1 = sel_q[0];

  for (genvar i = 0; i < IDSEL_N; i++) begin : g_idsel
    assign idsel[i] = (dev == DEV_W'(i));
  end

  always_comb begin
    phase = '0;
    if (type1) begin
      phase[23:16] = bus;
      phase[15:11] = dev;
      phase[10:8]  = fn;
      phase[7:2]   = regi;
      phase[1:0]   = 2'b01;
    end else begin
      phase[IDSEL_BASE +: IDSEL_N] = idsel;
      phase[10:8] = fn;
      phase[7:2]  = regi;
      phase[1:0]  = 2'b00;
    end
  end
endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
  import cfg_xlate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TMO_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                master_en,
  input  logic [TMO_W-1:0]    tmo_cycles,
  input  logic                host_valid,
  input  logic [1:0]          host_sel,
  input  logic                host_wr,
  input  logic [DATA_W-1:0]   host_wdata,
  input  logic [DATA_W/8-1:0] host_be,
  output logic                host_ready,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                host_err,
  input  logic [SELR_W-1:0]   sel_q,
  input  logic                mabort_q,
  input  logic [31:0]         phase,
  output logic                wr_sel_en,
  output logic                wr_stat_en,
  output logic                set_mabort,
  output logic                eng_req,
  output logic [31:0]         eng_addr,
  output logic [3:0]          eng_cmd,
  output logic [DATA_W/8-1:0] eng_be,
  output logic [DATA_W-1:0]   eng_wdata,
  input  logic                eng_done,
  input  logic [DATA_W-1:0]   eng_rdata,
  input  logic                eng_mabort
);
  localparam int CNT_W = TMO_W + 1;

  seq_state_t       state;
  logic [TMO_W-1:0] cnt;
  logic             accept;
  logic             expire;

  assign accept     = (state == ST_IDLE) && host_valid && !host_ready;
  assign wr_sel_en  = accept && host_wr && (host_sel == SEL_ADDR);
  assign wr_stat_en = accept && host_wr && (host_sel == SEL_STAT);
  assign set_mabort = (state == ST_WAIT) && eng_done && eng_mabort;
  assign expire     = (CNT_W'(cnt) + CNT_W'(1)) >= CNT_W'(tmo_cycles);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      host_ready <= 1'b0;
      host_rdata <= '0;
      host_err   <= 1'b0;
      eng_req    <= 1'b0;
      eng_addr   <= '0;
      eng_cmd    <= '0;
      eng_be     <= '0;
      eng_wdata  <= '0;
    end else begin
      host_ready <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            case (host_sel)
              SEL_ADDR: begin
                host_ready <= 1'b1;
                host_err   <= 1'b0;
                host_rdata <= host_wr ? '0 : DATA_W'(sel_q);
              end
              SEL_STAT: begin
                host_ready <= 1'b1;
                host_err   <= 1'b0;
                host_rdata <= host_wr ? '0 : DATA_W'(mabort_q);
              end
              SEL_DATA: begin
                if (master_en) begin
                  eng_req   <= 1'b1;
                  eng_addr  <= phase;
                  eng_cmd   <= host_wr ? CMD_CFG_WR : CMD_CFG_RD;
                  eng_be    <= host_be;
                  eng_wdata <= host_wr ? host_wdata : '0;
                  cnt       <= '0;
                  state     <= ST_WAIT;
                end
              end
              default: begin
                host_ready <= 1'b1;
                host_err   <= 1'b0;
                host_rdata <= '0;
              end
            endcase
          end
        end
        ST_WAIT: begin
          if (eng_done) begin
            eng_req    <= 1'b0;
            host_ready <= 1'b1;
            host_err   <= 1'b0;
            if (eng_cmd == CMD_CFG_RD)
              host_rdata <= eng_mabort ? '1 : eng_rdata;
            else
              host_rdata <= '0;
            state <= ST_IDLE;
          end else if (expire) begin
            eng_req    <= 1'b0;
            host_ready <= 1'b1;
            host_err   <= 1'b1;
            host_rdata <= '1;
            state      <= ST_IDLE;
          end else begin
            cnt <= cnt + TMO_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TMO_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                master_en,
  input  logic [TMO_W-1:0]    tmo_cycles,
  input  logic                host_valid,
  input  logic [1:0]          host_sel,
  input  logic                host_wr,
  input  logic [DATA_W-1:0]   host_wdata,
  input  logic [DATA_W/8-1:0] host_be,
  output logic                host_ready,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                host_err,
  output logic                eng_req,
  output logic [31:0]         eng_addr,
  output logic [3:0]          eng_cmd,
  output logic [DATA_W/8-1:0] eng_be,
  output logic [DATA_W-1:0]   eng_wdata,
  input  logic                eng_done,
  input  logic [DATA_W-1:0]   eng_rdata,
  input  logic                eng_mabort
);
  logic [SELR_W-1:0] sel_q;
  logic              mabort_q;
  logic [31:0]       phase;
  logic              wr_sel_en;
  logic              wr_stat_en;
  logic              set_mabort;

  cfg_sel_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_sel_en (wr_sel_en),
    .wr_stat_en(wr_stat_en),
    .wdata     (host_wdata),
    .set_mabort(set_mabort),
    .sel_q     (sel_q),
    .mabort_q  (mabort_q)
  );

  cfg_phase_enc #(.IDSEL_BASE(16), .IDSEL_N(16)) u_enc (
    .sel_q(sel_q),
    .phase(phase)
  );

  cfg_access_seq #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .master_en (master_en),
    .tmo_cycles(tmo_cycles),
    .host_valid(host_valid),
    .host_sel  (host_sel),
    .host_wr   (host_wr),
    .host_wdata(host_wdata),
    .host_be   (host_be),
    .host_ready(host_ready),
    .host_rdata(host_rdata),
    .host_err  (host_err),
    .sel_q     (sel_q),
    .mabort_q  (mabort_q),
    .phase     (phase),
    .wr_sel_en (wr_sel_en),
    .wr_stat_en(wr_stat_en),
    .set_mabort(set_mabort),
    .eng_req   (eng_req),
    .eng_addr  (eng_addr),
    .eng_cmd   (eng_cmd),
    .eng_be    (eng_be),
    .eng_wdata (eng_wdata),
    .eng_done  (eng_done),
    .eng_rdata (eng_rdata),
    .eng_mabort(eng_mabort)
  );
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              master_en,
  input logic              host_valid,
  input logic [1:0]        host_sel,
  input logic              host_ready,
  input logic              host_err,
  input logic [DATA_W-1:0] host_rdata,
  input logic              eng_req,
  input logic [31:0]       eng_addr,
  input logic [3:0]        eng_cmd
);
  // R1, R2: a request only follows a data-window access
  a_r2_launch_src: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_req) |-> $past(host_valid && host_sel == 2'b01));

  // R6: no launch without master enable
  a_r6_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_req) |-> $past(master_en));

  // R2: request fields hold while the request is up
  a_r2_stable: assert property (@(posedge clk) disable iff (rst)
    (eng_req && $past(eng_req)) |-> ($stable(eng_addr) && $stable(eng_cmd)));

  // R2: command code is one of the two configuration codes
  a_r2_cmd: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> (eng_cmd == 4'b1010 || eng_cmd == 4'b1011));

  // R3, R4: Type 0 IDSEL field is at most one-hot
  a_r3_idsel_onehot: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_addr[0]) |-> ($onehot0(eng_addr[31:16]) && eng_addr[1:0] == 2'b00));

  // R5: Type 1 low bits and top byte
  a_r5_type1_form: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_addr[0]) |-> (eng_addr[1:0] == 2'b01 && eng_addr[31:24] == 8'h00));

  // R7: ready is a single-cycle pulse
  a_r7_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);

  // R8: a timeout returns all ones
  a_r8_err_ones: assert property (@(posedge clk) disable iff (rst)
    (host_ready && host_err) |-> (host_rdata == {DATA_W{1'b1}}));
endmodule

bind cfg_xlate cfg_xlate_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .master_en (master_en),
  .host_valid(host_valid),
  .host_sel  (host_sel),
  .host_ready(host_ready),
  .host_err  (host_err),
  .host_rdata(host_rdata),
  .eng_req   (eng_req),
  .eng_addr  (eng_addr),
  .eng_cmd   (eng_cmd)
);

// File: tb/test_cfg_xlate.sv
`timescale 1ns/1ps
module test_cfg_xlate;
  localparam int DATA_W = 32;
  localparam int TMO_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              master_en = 1'b0;
  logic [TMO_W-1:0]  tmo_cycles = 4'd8;
  logic              host_valid = 1'b0;
  logic [1:0]        host_sel = 2'b00;
  logic              host_wr = 1'b0;
  logic [31:0]       host_wdata = '0;
  logic [3:0]        host_be = '0;
  logic              host_ready;
  logic [31:0]       host_rdata;
  logic              host_err;
  logic              eng_req;
  logic [31:0]       eng_addr;
  logic [3:0]        eng_cmd;
  logic [3:0]        eng_be;
  logic [31:0]       eng_wdata;
  logic              eng_done = 1'b0;
  logic [31:0]       eng_rdata = '0;
  logic              eng_mabort = 1'b0;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  cfg_xlate #(.DATA_W(DATA_W), .TMO_W(TMO_W)) i_cfg_xlate (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // results of the last access
  logic [31:0] r_data;
  logic        r_err;
  int          r_reqcyc;
  int          r_rises;
  logic [31:0] r_addr;
  logic [3:0]  r_cmd, r_be;
  logic [31:0] r_wdata;

  task automatic reg_acc(input logic [1:0] sel, input bit wr, input logic [31:0] wd);
    int n = 0;
    r_rises = 0;
    @(negedge clk);
    host_valid = 1'b1; host_sel = sel; host_wr = wr; host_wdata = wd; host_be = 4'hF;
    forever begin
      @(negedge clk);
      n++;
      if (eng_req) r_rises++;
      if (host_ready || n > 50) break;
    end
    r_data = host_rdata; r_err = host_err;
    host_valid = 1'b0;
  endtask

  task automatic data_acc(input bit wr, input logic [31:0] wd, input logic [3:0] be,
                          input int delay, input bit respond, input bit mab,
                          input logic [31:0] rd);
    int n = 0;
    bit prev = 0;
    r_reqcyc = 0; r_rises = 0;
    @(negedge clk);
    host_valid = 1'b1; host_sel = 2'b01; host_wr = wr; host_wdata = wd; host_be = be;
    forever begin
      @(negedge clk);
      n++;
      if (host_ready || n > 100) break;
      eng_done = 1'b0; eng_mabort = 1'b0;
      if (eng_req) begin
        if (!prev) r_rises++;
        r_reqcyc++;
        r_addr = eng_addr; r_cmd = eng_cmd; r_be = eng_be; r_wdata = eng_wdata;
        if (respond && r_reqcyc == delay) begin
          eng_done = 1'b1; eng_mabort = mab; eng_rdata = rd;
        end
      end
      prev = eng_req;
    end
    r_data = host_rdata; r_err = host_err;
    host_valid = 1'b0; eng_done = 1'b0; eng_mabort = 1'b0;
  endtask

  function automatic logic [31:0] exp_phase(input int bus, input int dev, input int fn,
                                            input int rg, input bit t1);
    logic [31:0] v;
    if (t1) v = 32'(bus) << 16 | 32'(dev) << 11 | 32'(fn) << 8 | 32'(rg) << 2 | 32'd1;
    else v = ((dev < 16) ? (32'd1 << (16 + dev)) : 32'd0) | 32'(fn) << 8 | 32'(rg) << 2;
    return v;
  endfunction

  function automatic logic [31:0] sel_val(input int bus, input int dev, input int fn,
                                          input int rg, input bit t1);
    return 32'(bus) << 16 | 32'(dev) << 11 | 32'(fn) << 8 | 32'(rg) << 2 | 32'(t1);
  endfunction

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] sv, ep;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!host_ready && !eng_req && !host_err, "reset", {30'd0, host_ready, eng_req}, 32'd0);

    // R1: selector write stores, no request; reserved byte reads zero
    reg_acc(2'b00, 1'b1, 32'hA5_12_3456);
    chk(r_rises == 0, "R1 no req on selector write", r_rises, 0);
    reg_acc(2'b00, 1'b0, 32'h0);
    chk(r_data == 32'h0012_3456, "R1 readback", r_data, 32'h0012_3456);

    // R6: gated master enable
    begin
      int seen = 0;
      @(negedge clk);
      host_valid = 1'b1; host_sel = 2'b01; host_wr = 1'b0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (host_ready || eng_req) seen++;
      end
      host_valid = 1'b0;
      chk(seen == 0, "R6 no response while disabled", seen, 0);
    end
    master_en = 1'b1;

    // R3/R4: Type 0 sweep over all devices
    for (int d = 0; d < 32; d++) begin
      int fn = d % 8, rg = (d * 5) % 64;
      sv = sel_val(d, d, fn, rg, 1'b0);
      reg_acc(2'b00, 1'b1, sv);
      data_acc(1'b0, 32'h0, 4'hF, 1 + d % 3, 1'b1, 1'b0, 32'hC0DE_0000 + 32'(d));
      ep = exp_phase(d, d, fn, rg, 1'b0);
      if (d < 16) chk(r_addr == ep, "R3 type0 idsel", r_addr, ep);
      else        chk(r_addr == ep, "R4 type0 high device", r_addr, ep);
      chk(r_cmd == 4'b1010 && r_rises == 1, "R2 read cmd once", {r_rises[3:0], r_cmd}, 8'h1A);
      chk(r_data == 32'hC0DE_0000 + 32'(d) && !r_err, "R7 read data", r_data, 32'hC0DE_0000 + 32'(d));
      chk(r_reqcyc == 1 + d % 3, "R7 waits for done", r_reqcyc, 1 + d % 3);
    end

    // R5: Type 1 sweep over bus numbers
    for (int b = 0; b < 256; b += 17) begin
      int dv = (b * 3) % 32, fn = b % 8, rg = (b * 7) % 64;
      sv = sel_val(b, dv, fn, rg, 1'b1);
      reg_acc(2'b00, 1'b1, sv | 32'hFF00_0000);
      data_acc(1'b1, 32'h1234_0000 + 32'(b), 4'(b), 2, 1'b1, 1'b0, 32'h0);
      ep = exp_phase(b, dv, fn, rg, 1'b1);
      chk(r_addr == ep, "R5 type1 word", r_addr, ep);
      chk(r_cmd == 4'b1011 && r_be == 4'(b), "R2 write cmd and be", {r_be, r_cmd}, {4'(b), 4'b1011});
      chk(r_wdata == 32'h1234_0000 + 32'(b), "R2 write data", r_wdata, 32'h1234_0000 + 32'(b));
    end

    // R8: timeout
    tmo_cycles = 4'd6;
    data_acc(1'b0, 32'h0, 4'hF, 0, 1'b0, 1'b0, 32'h0);
    chk(r_err && r_data == 32'hFFFF_FFFF, "R8 timeout result", r_data, 32'hFFFF_FFFF);
    chk(r_reqcyc == 6, "R8 timeout length", r_reqcyc, 6);
    tmo_cycles = 4'd0;
    data_acc(1'b0, 32'h0, 4'hF, 0, 1'b0, 1'b0, 32'h0);
    chk(r_err && r_reqcyc == 1, "R8 zero limit acts as one", r_reqcyc, 1);
    tmo_cycles = 4'd8;

    // R9: master abort
    reg_acc(2'b10, 1'b0, 32'h0);
    chk(r_data == 32'h0, "R9 status clear initially", r_data, 32'h0);
    data_acc(1'b0, 32'h0, 4'hF, 3, 1'b1, 1'b1, 32'h1111_2222);
    chk(r_data == 32'hFFFF_FFFF && !r_err, "R9 abort read ones", r_data, 32'hFFFF_FFFF);
    reg_acc(2'b10, 1'b1, 32'h0);
    reg_acc(2'b10, 1'b0, 32'h0);
    chk(r_data == 32'h1, "R9 sticky survives write of zero", r_data, 32'h1);
    reg_acc(2'b10, 1'b1, 32'h1);
    reg_acc(2'b10, 1'b0, 32'h0);
    chk(r_data == 32'h0, "R9 write one clears", r_data, 32'h0);
    data_acc(1'b1, 32'hDEAD_BEEF, 4'h3, 1, 1'b1, 1'b1, 32'h0);
    chk(!r_err && r_data == 32'h0, "R9 abort write completes", r_data, 32'h0);

    // R10: unmapped slot
    reg_acc(2'b11, 1'b0, 32'h0);
    chk(r_data == 32'h0 && r_rises == 0, "R10 unmapped", r_data, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule